// File: doc/BRIEF.md
# USB Line Bit Receiver

This block sits behind an oversampling front end that classifies the two USB data lines into one line symbol per clock. While the receiver is idle it watches for the first idle-to-K transition, which opens a packet. It then tracks bit timing with a fractional phase timer and samples every bit near its centre. The bit period is nudged on each transition bit, according to where the line edge was actually seen.

The sampled symbols are NRZI-decoded against the previous bit's symbol, and stuffed bits are dropped after a run of ones. The destuffed bits come out one per strobe, in line order, so the first bit on the wire comes out first. The sync field is included in that stream. A packet ends in one of four ways: a checked single-ended-zero end marker, a bit-stuff violation, a malformed end marker, or a sync followed by a low-speed preamble identifier. In the last case the block asks the front end to move to low-speed timing with full-speed polarity.

All outputs are registered single-cycle pulses. Each appears one clock after the sample point that causes it. The timer restarts from the nominal bit period at every start of packet.

Top module: `usbrx_bitrx`

## Requirements
- R1: After reset, and while no packet is in progress, every output pulse is low.
- R2: `line_sym` is coded 0 = SE0, 1 = J (idle), 2 = K, 3 = SE1. A start pulse is raised only when the receiver is idle, the line changes to K, and the last idle symbol seen was J.
- R3: Each sampled bit decodes to 0 when its symbol differs from the previous bit's symbol and to 1 when it is the same. The previous symbol is J at start of packet, so a sync field 0000_0001 (line order) is delivered as bits 0,0,0,0,0,0,0,1.
- R4: After six consecutive decoded ones, the next bit must be 0 and is discarded; `bit_vld_o` never pulses for it.
- R5: A 1 in the stuff position pulses `stuff_err_o` and returns the receiver to idle; no further bits of that packet are delivered.
- R6: An SE0 at a bit sample point starts end checking. SE0 at the next sample followed by J at the one after pulses `eop_o`. The receiver then waits while the line is SE0 before returning to idle.
- R7: Any other symbol sequence during end checking pulses `eop_err_o` and returns the receiver to idle.
- R8: If the first 16 delivered bits, in line order, are 0000000100111100, `ls_req_o` pulses together with the 16th bit. The receiver then returns to idle with its previous-symbol memory set to J.
- R9: The bit period is a fixed-point count of clock cycles with 8 fraction bits. It starts at the nominal value at each start of packet. On a transition bit whose expected-edge sample is J or K, it shrinks by 1/1024 if that sample already shows the new symbol. Otherwise it grows by 1/1024 and the sample point moves later by 1/128 of a bit. It is clamped to within 1/8 of nominal.
- R10: At most one of `sop_o`, `bit_vld_o`, `eop_o`, `stuff_err_o`, `eop_err_o` is high in any cycle.
- R11: An SE0 seen while idle parks the receiver until the line leaves SE0; a K that directly follows that SE0 does not open a packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one line symbol per cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| line_sym | input | 2 | Classified line symbol: 0 SE0, 1 J, 2 K, 3 SE1 |
| sop_o | output | 1 | Start-of-packet pulse |
| bit_vld_o | output | 1 | Pulse per delivered (destuffed) bit |
| bit_o | output | 1 | Decoded bit value, valid with `bit_vld_o` |
| eop_o | output | 1 | Valid end-of-packet pulse |
| stuff_err_o | output | 1 | Bit-stuff violation pulse |
| eop_err_o | output | 1 | Malformed end-of-packet pulse |
| ls_req_o | output | 1 | Sync plus low-speed preamble seen; request low-speed timing |

## Verification
The assertions take the symbol stream as clean: each symbol is held for a whole bit period close to the nominal one, and there are no glitches inside a bit. Only under that assumption do the sample-spacing and period-bound properties describe real traffic. The stimulus keeps to this by holding every NRZI symbol for exactly the nominal number of cycles and by placing a J idle gap between packets. Error packets are closed with an SE0 and J, so the receiver always comes back to idle before the next packet starts.

// File: rtl/usbrx_pkg.sv
package usbrx_pkg;
  typedef enum logic [1:0] {
    LS_SE0 = 2'd0,
    LS_J   = 2'd1,
    LS_K   = 2'd2,
    LS_SE1 = 2'd3
  } line_sym_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BIT   = 2'd1,
    ST_EOP   = 2'd2,
    ST_WIDLE = 2'd3
  } rx_state_e;
endpackage

// File: rtl/usbrx_phase.sv
module usbrx_phase #(
  parameter int NOM_CYCLES = 8,
  parameter int CNT_W      = 8,
  parameter int FRAC_W     = 8,
  parameter int ADJ_SH     = 10,
  parameter int MOVE_SH    = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  input  logic adj_dn,
  input  logic adj_up,
  output logic samp_o,
  output logic edge_o
);
  localparam int PW = CNT_W + FRAC_W;
  localparam logic [PW-1:0] ONE_Q  = PW'(1) << FRAC_W;
  localparam logic [PW-1:0] NOM_Q  = PW'(NOM_CYCLES) << FRAC_W;
  localparam logic [PW-1:0] HALF_Q = NOM_Q >> 1;
  localparam logic [PW-1:0] PMIN_Q = NOM_Q - (NOM_Q >> 3);
  localparam logic [PW-1:0] PMAX_Q = NOM_Q + (NOM_Q >> 3);

  logic [PW-1:0]    per_q, per_d, t_q, t_d;
  logic [PW-1:0]    per_raw, per_new, move;
  logic [CNT_W-1:0] t_int, half_int;

  assign t_int    = t_q[PW-1:FRAC_W];
  assign half_int = {1'b0, per_q[PW-1:FRAC_W+1]};
  assign samp_o   = run && (t_int == '0);
  assign edge_o   = run && (t_int == half_int + CNT_W'(1));
  assign move     = per_q >> MOVE_SH;

  always_comb begin
    if (adj_dn)      per_raw = per_q - (per_q >> ADJ_SH);
    else if (adj_up) per_raw = per_q + (per_q >> ADJ_SH);
    else             per_raw = per_q;
    if (per_raw < PMIN_Q)      per_new = PMIN_Q;
    else if (per_raw > PMAX_Q) per_new = PMAX_Q;
    else                       per_new = per_raw;
  end

  always_comb begin
    per_d = per_q;
    t_d   = t_q;
    if (start) begin
      per_d = NOM_Q;
      t_d   = HALF_Q;
    end else if (run) begin
      if (samp_o) begin
        per_d = per_new;
        t_d   = t_q + per_new - ONE_Q + (adj_up ? move : '0);
      end else begin
        t_d = t_q - ONE_Q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q <= NOM_Q;
      t_q   <= HALF_Q;
    end else if (start || run) begin
      per_q <= per_d;
      t_q   <= t_d;
    end
  end

  // R9
  per_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (per_q >= PMIN_Q) && (per_q <= PMAX_Q));

  // R9
  per_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !start) |=> ((per_q <= $past(per_q) + ($past(per_q) >> ADJ_SH)) &&
                         (per_q + ($past(per_q) >> ADJ_SH) >= $past(per_q))));

  // R9
  samp_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_o && run) |=> !samp_o);
endmodule

// File: rtl/usbrx_destuff.sv
module usbrx_destuff #(
  parameter int          RUN_LEN = 6,
  parameter int          WIN     = 16,
  parameter logic [15:0] PRE_PAT = 16'b0000000100111100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic samp,
  input  logic bit_i,
  output logic data_vld,
  output logic stuff_err,
  output logic pre_hit
);
  localparam int OW = $clog2(RUN_LEN + 1);
  localparam int CW = $clog2(WIN + 1);

  logic [OW-1:0]  ones_q, ones_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [WIN-1:0] win_q, win_d, win_nx;
  logic           at_stuff;

  assign at_stuff  = (ones_q == OW'(RUN_LEN));
  assign data_vld  = samp && !at_stuff;
  assign stuff_err = samp && at_stuff && bit_i;
  assign win_nx    = {win_q[WIN-2:0], bit_i};
  assign pre_hit   = data_vld && (cnt_q == CW'(WIN - 1)) && (win_nx == WIN'(PRE_PAT));

  always_comb begin
    ones_d = ones_q;
    cnt_d  = cnt_q;
    win_d  = win_q;
    if (clr) begin
      ones_d = '0;
      cnt_d  = '0;
      win_d  = '0;
    end else if (samp) begin
      if (at_stuff)   ones_d = '0;
      else if (bit_i) ones_d = ones_q + OW'(1);
      else            ones_d = '0;
      if (data_vld && (cnt_q < CW'(WIN))) begin
        cnt_d = cnt_q + CW'(1);
        win_d = win_nx;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones_q <= '0;
      cnt_q  <= '0;
      win_q  <= '0;
    end else if (clr || samp) begin
      ones_q <= ones_d;
      cnt_q  <= cnt_d;
      win_q  <= win_d;
    end
  end

  // R4
  run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ones_q <= OW'(RUN_LEN));

  // R8
  win_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(WIN));
endmodule

// File: rtl/usbrx_bitrx.sv
module usbrx_bitrx
  import usbrx_pkg::*;
#(
  parameter int          NOM_CYCLES = 8,
  parameter int          CNT_W      = 8,
  parameter int          FRAC_W     = 8,
  parameter int          RUN_LEN    = 6,
  parameter int          PRE_WIN    = 16,
  parameter logic [15:0] PRE_PAT    = 16'b0000000100111100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] line_sym,
  output logic       sop_o,
  output logic       bit_vld_o,
  output logic       bit_o,
  output logic       eop_o,
  output logic       stuff_err_o,
  output logic       eop_err_o,
  output logic       ls_req_o
);
  rx_state_e state_q, state_d;
  line_sym_e sym, prev_q, prev_d, line_q, edge_q, edge_d;
  logic      two_q, two_d;
  logic      sop_d, vld_d, bit_d, eop_d, serr_d, eerr_d, lsr_d;
  logic      run, samp, edge_stb, sop_hit, nrzi_one, bit_samp, edge_ok;
  logic      adj_dn, adj_up, data_vld, stuff_err, pre_hit;

  assign sym      = line_sym_e'(line_sym);
  assign run      = (state_q == ST_BIT) || (state_q == ST_EOP);
  assign sop_hit  = (state_q == ST_IDLE) && (sym == LS_K) && (line_q != LS_K) && (prev_q == LS_J);
  assign nrzi_one = (sym == prev_q);
  assign bit_samp = (state_q == ST_BIT) && samp && (sym != LS_SE0);
  assign edge_ok  = (edge_q == LS_J) || (edge_q == LS_K);
  assign adj_dn   = bit_samp && !nrzi_one && edge_ok && (edge_q == sym);
  assign adj_up   = bit_samp && !nrzi_one && edge_ok && (edge_q != sym);

  usbrx_phase #(
    .NOM_CYCLES(NOM_CYCLES),
    .CNT_W     (CNT_W),
    .FRAC_W    (FRAC_W),
    .ADJ_SH    (10),
    .MOVE_SH   (7)
  ) u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .start (sop_hit),
    .run   (run),
    .adj_dn(adj_dn),
    .adj_up(adj_up),
    .samp_o(samp),
    .edge_o(edge_stb)
  );

  usbrx_destuff #(
    .RUN_LEN(RUN_LEN),
    .WIN    (PRE_WIN),
    .PRE_PAT(PRE_PAT)
  ) u_destuff (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (sop_hit),
    .samp     (bit_samp),
    .bit_i    (nrzi_one),
    .data_vld (data_vld),
    .stuff_err(stuff_err),
    .pre_hit  (pre_hit)
  );

  always_comb begin
    state_d = state_q;
    prev_d  = prev_q;
    edge_d  = edge_q;
    two_d   = two_q;
    sop_d   = 1'b0;
    vld_d   = 1'b0;
    bit_d   = 1'b0;
    eop_d   = 1'b0;
    serr_d  = 1'b0;
    eerr_d  = 1'b0;
    lsr_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (sym == LS_SE0) begin
          state_d = ST_WIDLE;
        end else if (sop_hit) begin
          state_d = ST_BIT;
          sop_d   = 1'b1;
          edge_d  = LS_K;
        end else if (sym != line_q) begin
          prev_d = sym;
        end
      end
      ST_BIT: begin
        if (edge_stb) edge_d = sym;
        if (samp) begin
          if (sym == LS_SE0) begin
            state_d = ST_EOP;
            two_d   = 1'b0;
          end else begin
            prev_d = sym;
            if (stuff_err) begin
              serr_d  = 1'b1;
              state_d = ST_IDLE;
            end else if (data_vld) begin
              vld_d = 1'b1;
              bit_d = nrzi_one;
              if (pre_hit) begin
                lsr_d   = 1'b1;
                state_d = ST_IDLE;
                prev_d  = LS_J;
              end
            end
          end
        end
      end
      ST_EOP: begin
        if (samp) begin
          if ((sym == LS_SE0) && !two_q) begin
            two_d = 1'b1;
          end else if ((sym == LS_J) && two_q) begin
            eop_d   = 1'b1;
            state_d = ST_WIDLE;
          end else begin
            eerr_d  = 1'b1;
            state_d = ST_IDLE;
            prev_d  = sym;
          end
        end
      end
      ST_WIDLE: begin
        if (sym != LS_SE0) begin
          state_d = ST_IDLE;
          prev_d  = sym;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      prev_q      <= LS_J;
      line_q      <= LS_J;
      edge_q      <= LS_J;
      two_q       <= 1'b0;
      sop_o       <= 1'b0;
      bit_vld_o   <= 1'b0;
      bit_o       <= 1'b0;
      eop_o       <= 1'b0;
      stuff_err_o <= 1'b0;
      eop_err_o   <= 1'b0;
      ls_req_o    <= 1'b0;
    end else begin
      state_q     <= state_d;
      prev_q      <= prev_d;
      line_q      <= sym;
      edge_q      <= edge_d;
      two_q       <= two_d;
      sop_o       <= sop_d;
      bit_vld_o   <= vld_d;
      bit_o       <= bit_d;
      eop_o       <= eop_d;
      stuff_err_o <= serr_d;
      eop_err_o   <= eerr_d;
      ls_req_o    <= lsr_d;
    end
  end

  // R10
  one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sop_o, bit_vld_o, eop_o, stuff_err_o, eop_err_o}));

  // R2
  sop_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sop_o |-> (state_q == ST_BIT));

  // R3
  bit_in_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld_o |-> ($past(state_q) == ST_BIT));

  // R5
  stuff_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_err_o |-> (state_q == ST_IDLE));

  // R6
  eop_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eop_o |-> (state_q == ST_WIDLE));

  // R7
  eop_err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eop_err_o |-> (state_q == ST_IDLE));

  // R8
  pre_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ls_req_o |-> ((state_q == ST_IDLE) && bit_vld_o));

  // R11
  widle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_WIDLE) && (sym == LS_SE0)) |=> (state_q == ST_WIDLE));
endmodule

// File: tb/tb_usbrx_bitrx.sv
module tb_usbrx_bitrx;
  localparam int PER    = 8;
  localparam int K_SOP  = 0;
  localparam int K_BIT  = 1;
  localparam int K_EOP  = 2;
  localparam int K_SERR = 3;
  localparam int K_EERR = 4;
  localparam int K_PRE  = 5;

  logic       clk, rst_n;
  logic [1:0] line_sym;
  logic       sop_o, bit_vld_o, bit_o, eop_o, stuff_err_o, eop_err_o, ls_req_o;

  int total, bad, ones, cur_sym;
  bit done;
  int exp_q[$];
  int raw_q[$];

  usbrx_bitrx #(.NOM_CYCLES(PER)) dut (
    .clk(clk), .rst_n(rst_n), .line_sym(line_sym),
    .sop_o(sop_o), .bit_vld_o(bit_vld_o), .bit_o(bit_o), .eop_o(eop_o),
    .stuff_err_o(stuff_err_o), .eop_err_o(eop_err_o), .ls_req_o(ls_req_o)
  );

  initial begin
    clk = 1'b0;
    forever #2 clk = ~clk;
  end

  function automatic string req_of(int k);
    case (k)
      K_SOP:   return "R2";
      K_BIT:   return "R3";
      K_EOP:   return "R6";
      K_SERR:  return "R5";
      K_EERR:  return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check_evt(int kind, int b);
    int e;
    total++;
    if (exp_q.size() == 0) begin
      bad++;
      $display("FAIL %s unexpected event actual=%0d expected=none", req_of(kind), kind * 2 + b);
    end else begin
      e = exp_q.pop_front();
      if (e != kind * 2 + b) begin
        bad++;
        $display("FAIL %s event actual=%0d expected=%0d", req_of(kind), kind * 2 + b, e);
      end
    end
  endtask

  // Reference comparison on every clock, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if ((int'(sop_o) + int'(bit_vld_o) + int'(eop_o) + int'(stuff_err_o) + int'(eop_err_o)) > 1) begin
        total++;
        bad++;
        $display("FAIL R10 several pulses actual=%b expected=one-hot",
                 {sop_o, bit_vld_o, eop_o, stuff_err_o, eop_err_o});
      end
      if (sop_o)       check_evt(K_SOP, 0);
      if (bit_vld_o)   check_evt(K_BIT, int'(bit_o));
      if (eop_o)       check_evt(K_EOP, 0);
      if (stuff_err_o) check_evt(K_SERR, 0);
      if (eop_err_o)   check_evt(K_EERR, 0);
      if (ls_req_o)    check_evt(K_PRE, 0);
    end
  end

  task automatic expect_evt(int kind, int b);
    exp_q.push_back(kind * 2 + b);
  endtask

  // Behavioural transmitter: stuffs a zero after six ones (R4).
  task automatic push_data(int b);
    raw_q.push_back(b);
    expect_evt(K_BIT, b);
    if (b != 0) ones++;
    else ones = 0;
    if (ones == 6) begin
      raw_q.push_back(0);
      ones = 0;
    end
  endtask

  task automatic push_byte(int v);
    for (int i = 0; i < 8; i++) push_data((v >> i) & 1);
  endtask

  task automatic begin_pkt();
    raw_q.delete();
    ones = 0;
    expect_evt(K_SOP, 0);
    push_byte(8'h80);
  endtask

  task automatic drive(int s, int n);
    line_sym = 2'(s);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_raw();
    cur_sym = 1;
    foreach (raw_q[i]) begin
      if (raw_q[i] == 0) cur_sym = (cur_sym == 1) ? 2 : 1;
      drive(cur_sym, PER);
    end
  endtask

  task automatic good_eop();
    expect_evt(K_EOP, 0);
    drive(0, 2 * PER);
    drive(1, PER);
  endtask

  task automatic idle_check(string r);
    drive(1, 4 * PER);
    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL %s missing events actual=%0d expected=0", r, exp_q.size());
      exp_q.delete();
    end
  endtask

  initial begin
    total    = 0;
    bad      = 0;
    done     = 1'b0;
    ones     = 0;
    line_sym = 2'd1;
    rst_n    = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: outputs quiet after reset on an idle line
    total++;
    if ({sop_o, bit_vld_o, eop_o, stuff_err_o, eop_err_o, ls_req_o} != 6'b0) begin
      bad++;
      $display("FAIL R1 reset outputs actual=%b expected=000000",
               {sop_o, bit_vld_o, eop_o, stuff_err_o, eop_err_o, ls_req_o});
    end
    idle_check("R1");

    // R2 R3 R6: plain packet
    begin_pkt();
    push_byte(8'hA5);
    send_raw();
    good_eop();
    idle_check("R6");

    // R4: long runs of ones force stuff bits
    begin_pkt();
    push_byte(8'hFF);
    push_byte(8'hFF);
    push_byte(8'h7E);
    send_raw();
    good_eop();
    idle_check("R4");

    // R5: seventh one in a row
    begin_pkt();
    for (int i = 0; i < 5; i++) begin
      raw_q.push_back(1);
      expect_evt(K_BIT, 1);
    end
    raw_q.push_back(1);
    expect_evt(K_SERR, 0);
    send_raw();
    drive(0, 2 * PER);
    idle_check("R5");

    // R7: end marker with a single SE0 bit
    begin_pkt();
    push_byte(8'h3A);
    send_raw();
    expect_evt(K_EERR, 0);
    drive(0, PER);
    drive(1, PER);
    idle_check("R7");

    // R8: sync plus low-speed preamble; line left at K, then back to J
    begin_pkt();
    push_byte(8'h3C);
    expect_evt(K_PRE, 0);
    send_raw();
    idle_check("R8");

    // R8: a normal packet still decodes after the preamble
    begin_pkt();
    push_byte(8'hC3);
    send_raw();
    good_eop();
    idle_check("R8");

    // R11: SE0 then K while idle opens no packet
    drive(0, 3 * PER);
    drive(2, 2 * PER);
    idle_check("R11");

    // R9: long packet relies on the adaptive period staying centred
    begin_pkt();
    for (int i = 0; i < 12; i++) push_byte((i * 37 + 11) & 8'hFF);
    send_raw();
    good_eop();
    idle_check("R9");

    // R3: alternating ones and zeros
    begin_pkt();
    push_byte(8'h55);
    push_byte(8'h00);
    send_raw();
    good_eop();
    idle_check("R3");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule